// File: doc/BRIEF.md
# Eight-Channel Protection and Open-Load Fault Latch

This block guards eight low-side output channels. For each channel it receives three digital condition inputs from analog comparators that sit outside the block: an overload indication, an overtemperature indication, and an indication that the output voltage is below the open-load threshold. It also receives the channel's commanded on/off state and a standby request. Every channel runs a small state machine with two qualifying delay counters. The block drives the real enable of each power stage, and it latches a protection flag and an open-load flag for each channel.

Overload counts only while the channel is driven on. Open-load counts only while the channel is off and out of standby. Each condition must persist for a delay, given as a parameter in clock cycles, before its flag is set. A protection fault forces the channel off and holds it off. The only way out is to put the channel in standby, which clears both flags. A capture strobe copies all sixteen flags into a register that holds steady for the serial interface, which reads it at the start of a frame.

Per-channel states: `CH_STANDBY` (output off, flags cleared, counters held at zero), `CH_OFF` (output off, open-load counter active), `CH_ON` (output driven, overload counter active) and `CH_LOCKED` (protection flag set, output off, open-load counter active). Transitions are checked in priority order:
- standby request → `CH_STANDBY` from any state;
- overtemperature → `CH_LOCKED` from any state outside standby;
- overload delay expiry in `CH_ON` → `CH_LOCKED`;
- command high in `CH_STANDBY` or `CH_OFF` → `CH_ON`;
- command low in `CH_STANDBY` or `CH_ON` → `CH_OFF`;
- `CH_LOCKED` stays in place until standby.

Top module: `relay_fault_guard`

## Requirements
- R1: While `rst_n` is low and after its release, every bit of `drive_on`, `prot_flags`, `open_flags` and `diag_snap` is 0, and every channel starts in standby.
- R2: When a channel is on and its overload input is high for `OVL_DLY` consecutive clock edges, `drive_on` of that channel is 0 and its `prot_flags` bit is 1 after the last of those edges. After `OVL_DLY-1` edges the channel is still driven and unflagged.
- R3: Each delay counter restarts from zero when its condition is low at a clock edge before expiry. A run of `DLY-1` edges, one edge without the condition, and another `DLY-1` edges leaves the flag clear.
- R4: An overtemperature input high at a clock edge, with the channel out of standby, sets its protection flag and clears its drive after that edge, whether the channel was on or off.
- R5: Open-load counts only while the channel is off or locked and out of standby. The flag is set after `OL_DLY` consecutive qualifying edges. A channel that is on never sets its open-load flag.
- R6: A channel whose protection flag is set keeps `drive_on` at 0 and the flag at 1 while its command is high and its conditions are gone, until it is put in standby.
- R7: A standby request high at a clock edge clears both flags of that channel after that edge and holds both counters at zero. This holds even when a set condition occurs at the same edge. After standby is released, the full delay is needed again.
- R8: At a clock edge with `capture` high, `diag_snap` takes the flags, with open-load flag n at bit `NCH+n` and protection flag n at bit n. Without `capture`, `diag_snap` does not change.
- R9: Channels are independent: a fault on one channel changes no drive or flag of another.
- R10: Out of standby and without a protection flag, `drive_on` of a channel follows its command one clock edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_standby | input | 8 | Per-channel standby request; clears the flags |
| ch_cmd_on | input | 8 | Per-channel commanded on state |
| ovl_det | input | 8 | Per-channel overload comparator output |
| otemp_det | input | 8 | Per-channel overtemperature sensor output |
| low_det | input | 8 | Per-channel output-below-open-load-threshold comparator output |
| capture | input | 1 | Copies the flags into `diag_snap` |
| drive_on | output | 8 | Per-channel power stage enable |
| prot_flags | output | 8 | Latched protection fault flags |
| open_flags | output | 8 | Latched open-load flags |
| diag_snap | output | 16 | Captured flag word: open-load in the upper half, protection in the lower half |

## Verification
The two functions that can land on the same clock edge are the standby clear and a flag set, from overtemperature or from expiry of the open-load delay. The bench raises overtemperature and the standby request on a channel in the same cycle, while that channel's open-load condition is held high. It judges the result as both flags reading zero after that edge. It then releases standby with the low-output condition still present and checks that the open-load flag needs the complete delay again. This shows the counter was really held at zero and not just masked.

// File: rtl/rfg_pkg.sv
package rfg_pkg;
    typedef enum logic [1:0] {
        CH_STANDBY = 2'd0,
        CH_OFF     = 2'd1,
        CH_ON      = 2'd2,
        CH_LOCKED  = 2'd3
    } ch_state_e;
endpackage

// File: rtl/rfg_delay.sv
// Qualifying delay: expires when the condition has held for DLY edges.
module rfg_delay #(
    parameter int DLY = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic qual,
    output logic expired
);
    localparam int CW = $clog2(DLY + 1);
    localparam logic [CW-1:0] LAST = CW'(DLY - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!qual) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = qual && (cnt == LAST);
endmodule

// File: rtl/rfg_chan.sv
// One channel: state machine, two delay counters, open-load latch.
module rfg_chan
    import rfg_pkg::*;
#(
    parameter int OVL_DLY = 6,
    parameter int OL_DLY  = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stby,
    input  logic cmd_on,
    input  logic ovl,
    input  logic otemp,
    input  logic low,
    output logic drive,
    output logic prot,
    output logic open_ld
);
    ch_state_e state, state_nx;
    logic      ovl_qual, ol_qual, ovl_exp, ol_exp;

    assign ovl_qual = (state == CH_ON) && ovl && !stby;
    assign ol_qual  = ((state == CH_OFF) || (state == CH_LOCKED)) && low && !stby;

    rfg_delay #(.DLY(OVL_DLY)) u_ovl_dly (
        .clk(clk), .rst_n(rst_n), .qual(ovl_qual), .expired(ovl_exp)
    );

    rfg_delay #(.DLY(OL_DLY)) u_ol_dly (
        .clk(clk), .rst_n(rst_n), .qual(ol_qual), .expired(ol_exp)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= CH_STANDBY;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        if (stby) begin
            state_nx = CH_STANDBY;
        end else if (otemp) begin
            state_nx = CH_LOCKED;
        end else begin
            unique case (state)
                CH_STANDBY: state_nx = cmd_on ? CH_ON : CH_OFF;
                CH_OFF:     state_nx = cmd_on ? CH_ON : CH_OFF;
                CH_ON:      state_nx = ovl_exp ? CH_LOCKED : (cmd_on ? CH_ON : CH_OFF);
                CH_LOCKED:  state_nx = CH_LOCKED;
            endcase
        end
    end

    // open-load latch, cleared by standby with priority
    always_ff @(posedge clk) begin
        if (!rst_n)      open_ld <= 1'b0;
        else if (stby)   open_ld <= 1'b0;
        else if (ol_exp) open_ld <= 1'b1;
    end

    // outputs
    always_comb begin
        drive = 1'b0;
        prot  = 1'b0;
        unique case (state)
            CH_STANDBY: ;
            CH_OFF:     ;
            CH_ON:      drive = 1'b1;
            CH_LOCKED:  prot  = 1'b1;
        endcase
    end
endmodule

// File: rtl/rfg_snap.sv
// Flag word held steady between capture strobes.
module rfg_snap #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         capture,
    input  logic [W-1:0] flags,
    output logic [W-1:0] snap
);
    always_ff @(posedge clk) begin
        if (!rst_n)       snap <= '0;
        else if (capture) snap <= flags;
    end
endmodule

// File: rtl/relay_fault_guard.sv
module relay_fault_guard #(
    parameter int NCH     = 8,
    parameter int OVL_DLY = 6,
    parameter int OL_DLY  = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   ch_standby,
    input  logic [NCH-1:0]   ch_cmd_on,
    input  logic [NCH-1:0]   ovl_det,
    input  logic [NCH-1:0]   otemp_det,
    input  logic [NCH-1:0]   low_det,
    input  logic             capture,
    output logic [NCH-1:0]   drive_on,
    output logic [NCH-1:0]   prot_flags,
    output logic [NCH-1:0]   open_flags,
    output logic [2*NCH-1:0] diag_snap
);
    localparam int SNAP_W = 2 * NCH;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        rfg_chan #(.OVL_DLY(OVL_DLY), .OL_DLY(OL_DLY)) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .stby   (ch_standby[i]),
            .cmd_on (ch_cmd_on[i]),
            .ovl    (ovl_det[i]),
            .otemp  (otemp_det[i]),
            .low    (low_det[i]),
            .drive  (drive_on[i]),
            .prot   (prot_flags[i]),
            .open_ld(open_flags[i])
        );
    end

    rfg_snap #(.W(SNAP_W)) u_snap (
        .clk    (clk),
        .rst_n  (rst_n),
        .capture(capture),
        .flags  ({open_flags, prot_flags}),
        .snap   (diag_snap)
    );
endmodule

// File: rtl/rfg_chk.sv
module rfg_chk #(
    parameter int NCH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NCH-1:0]   ch_standby,
    input logic [NCH-1:0]   ch_cmd_on,
    input logic [NCH-1:0]   otemp_det,
    input logic             capture,
    input logic [NCH-1:0]   drive_on,
    input logic [NCH-1:0]   prot_flags,
    input logic [NCH-1:0]   open_flags,
    input logic [2*NCH-1:0] diag_snap
);
    // R1: reset leaves every output cleared
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (drive_on == '0 && prot_flags == '0 && open_flags == '0 && diag_snap == '0));

    // R8: snapshot only moves on capture
    a_r8_snap_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(diag_snap));

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        // R4: overtemperature trips the channel
        a_r4_otemp_trip: assert property (@(posedge clk) disable iff (!rst_n)
            (otemp_det[i] && !ch_standby[i]) |=> (prot_flags[i] && !drive_on[i]));

        // R6: a protection flag holds until standby
        a_r6_lock_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (prot_flags[i] && !ch_standby[i]) |=> (prot_flags[i] && !drive_on[i]));

        // R7: standby clears both flags
        a_r7_stby_clear: assert property (@(posedge clk) disable iff (!rst_n)
            ch_standby[i] |=> (!prot_flags[i] && !open_flags[i]));

        // R5: no open-load set while driven on
        a_r5_no_ol_on: assert property (@(posedge clk) disable iff (!rst_n)
            drive_on[i] |=> !$rose(open_flags[i]));
    end
endmodule

bind relay_fault_guard rfg_chk #(.NCH(NCH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ch_standby(ch_standby),
    .ch_cmd_on (ch_cmd_on),
    .otemp_det (otemp_det),
    .capture   (capture),
    .drive_on  (drive_on),
    .prot_flags(prot_flags),
    .open_flags(open_flags),
    .diag_snap (diag_snap)
);

// File: tb/relay_fault_guard_test.sv
`timescale 1ns/1ps
module relay_fault_guard_test;
    localparam int NCH = 8;
    localparam int OD  = 6;
    localparam int LD  = 12;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [NCH-1:0]   stby, cmd, ovl, otemp, low;
    logic             capture;
    logic [NCH-1:0]   drive_on, prot_flags, open_flags;
    logic [2*NCH-1:0] diag_snap;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #4 clk = ~clk;

    relay_fault_guard #(.NCH(NCH), .OVL_DLY(OD), .OL_DLY(LD)) uut (
        .clk(clk), .rst_n(rst_n), .ch_standby(stby), .ch_cmd_on(cmd),
        .ovl_det(ovl), .otemp_det(otemp), .low_det(low), .capture(capture),
        .drive_on(drive_on), .prot_flags(prot_flags), .open_flags(open_flags),
        .diag_snap(diag_snap)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle_all();
        stby = '1; cmd = '0; ovl = '0; otemp = '0; low = '0; capture = 1'b0;
        tick(1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        stby = '1; cmd = '1; ovl = '1; otemp = '1; low = '1; capture = 1'b1;
        tick(3);
        check("R1 drive in reset", drive_on, 0);
        check("R1 prot in reset", prot_flags, 0);
        check("R1 open in reset", open_flags, 0);
        check("R1 snap in reset", diag_snap, 0);
        stby = '1; cmd = '0; ovl = '0; otemp = '0; low = '0; capture = 1'b0;
        rst_n = 1'b1;
        tick(1);
        check("R1 after release", {drive_on, prot_flags, open_flags}, 0);
    endtask

    task automatic t_switch();
        stby[0] = 1'b0; cmd[0] = 1'b1;
        tick(1);
        check("R10 drive follows on", drive_on, 32'h01);
        cmd[0] = 1'b0;
        tick(1);
        check("R10 drive follows off", drive_on, 0);
        idle_all();
    endtask

    task automatic t_overload();
        stby[1:0] = 2'b00; cmd[1:0] = 2'b11;
        tick(1);
        ovl[0] = 1'b1;
        tick(OD - 1);
        check("R2 short overload keeps drive", drive_on[0], 1);
        check("R2 short overload no flag", prot_flags[0], 0);
        ovl[0] = 1'b0;
        tick(1);
        ovl[0] = 1'b1;
        tick(OD - 1);
        check("R3 overload counter restarted", {drive_on[0], prot_flags[0]}, 2'b10);
        tick(1);
        check("R2 overload trips drive", drive_on[0], 0);
        check("R2 overload sets flag", prot_flags[0], 1);
        check("R9 neighbour drive kept", drive_on[1], 1);
        check("R9 neighbour flags clear", {prot_flags[NCH-1:1], open_flags}, 0);
        idle_all();
        check("R7 overload flag cleared", prot_flags, 0);
    endtask

    task automatic t_otemp_lock();
        stby[3:1] = 3'b000; cmd[1] = 1'b1; cmd[3] = 1'b1;
        tick(1);
        otemp[1] = 1'b1; otemp[2] = 1'b1; otemp[3] = 1'b1;
        tick(1);
        check("R4 otemp trips on channels", prot_flags[3:1], 3'b111);
        check("R4 otemp drive off", drive_on[3:1], 0);
        otemp[3:1] = 3'b000;
        tick(3);
        check("R6 locked with command high", {drive_on[3], prot_flags[3]}, 2'b01);
        check("R6 locked channel one", {drive_on[1], prot_flags[1]}, 2'b01);
        idle_all();
    endtask

    task automatic t_openload();
        stby[5:4] = 2'b00; cmd[5] = 1'b1; low[5:4] = 2'b11;
        tick(1);
        tick(LD - 1);
        check("R5 open-load before delay", open_flags[4], 0);
        tick(1);
        check("R5 open-load after delay", open_flags[4], 1);
        tick(4);
        check("R5 no open-load while on", open_flags[5], 0);
        check("R10 on channel still driven", drive_on[5], 1);
        stby[5] = 1'b1; cmd[5] = 1'b0; low[5] = 1'b0;
        tick(1);
    endtask

    task automatic t_standby_race();
        // ch4 still off, low held, open flag set
        stby[4] = 1'b1; otemp[4] = 1'b1;
        tick(1);
        check("R7 standby beats otemp", prot_flags[4], 0);
        check("R7 standby clears open", open_flags[4], 0);
        stby[4] = 1'b0; otemp[4] = 1'b0;
        tick(LD);
        check("R7 counter held at zero", open_flags[4], 0);
        tick(1);
        check("R7 full delay after standby", open_flags[4], 1);
        idle_all();
    endtask

    task automatic t_ol_restart();
        stby[6] = 1'b0; low[6] = 1'b1;
        tick(LD);
        low[6] = 1'b0;
        tick(1);
        low[6] = 1'b1;
        tick(LD - 1);
        check("R3 open-load counter restarted", open_flags[6], 0);
        tick(1);
        check("R3 open-load after full run", open_flags[6], 1);
        idle_all();
    endtask

    task automatic t_snapshot();
        stby[0] = 1'b0; otemp[0] = 1'b1; stby[7] = 1'b0; low[7] = 1'b1;
        tick(1);
        otemp[0] = 1'b0;
        tick(LD);
        check("R8 flags ready", {open_flags, prot_flags}, 16'h8001);
        check("R8 snap holds without capture", diag_snap, 0);
        capture = 1'b1;
        tick(1);
        capture = 1'b0;
        check("R8 snap captured layout", diag_snap, 16'h8001);
        idle_all();
        check("R8 snap stable after clear", diag_snap, 16'h8001);
        capture = 1'b1;
        tick(1);
        capture = 1'b0;
        check("R8 snap recaptured", diag_snap, 0);
    endtask

    initial begin
        t_reset();
        t_switch();
        t_overload();
        t_otemp_lock();
        t_openload();
        t_standby_race();
        t_ol_restart();
        t_snapshot();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule